// File: doc/BRIEF.md
# TDM Serial Frame Transmitter

This block drains 32-bit words from an upstream FIFO and sends them on a single serial data pin as a time-division-multiplexed frame. A one-cycle bit-time pulse (`bit_en`) paces it. Each pulse is one edge of the serial bit clock, and on that edge the block presents the next bit. A frame holds 1 to 32 slots. Slot 0 has its own width, and every later slot shares a second width. Each width runs from 1 to 32 bits.

In each word the bit sent first is configurable. The walk through the word goes downward or upward, so both MSB-first and LSB-first layouts work, including left- or right-justified placement of a short sample inside the 32-bit word. A per-slot mask takes the data pin out of drive for that slot, and a masked slot does not consume a FIFO word.

When the block is the frame-sync master it drives a sync pulse. The pulse has a programmable length and polarity. It can start together with the first frame bit, or one bit earlier. Clearing the enable in the middle of a frame lets that frame finish before the block goes idle.

Top module: `tdm_tx_serializer`

## Requirements
- R1: After reset, `sd_oe` is 0, `sd_out` is 0, `fifo_pop` is 0, `active` is 0, and `fsync_out` sits at its inactive level (equal to `sync_pol`).
- R2: A frame has `frame_words`+1 slots. Slot 0 is `word0_bits`+1 bits long and every other slot is `wordn_bits`+1 bits long. While `tx_enable` stays 1, frames follow one another with no gap.
- R3: The first bit sent in every slot is bit index `first_bit` of the word. With `msb_first`=1 each later bit has an index one lower, and with `msb_first`=0 each later bit has an index one higher. Indices wrap modulo 32.
- R4: The sync pulse is active for `sync_width`+1 bit times. `sync_pol`=0 gives an active-high pulse and `sync_pol`=1 gives an active-low pulse. With `sync_early`=0 the first active bit coincides with slot 0, bit 0.
- R5: With `sync_early`=1 the pulse starts one bit time before each frame. A frame started from idle is preceded by one lead bit time, during which the sync is active and `sd_oe` is 0.
- R6: A slot whose bit in `slot_mask` is 1 (bit w for slot w) holds `sd_oe` at 0 and `sd_out` at 0 for its whole length, and pops no FIFO word.
- R7: If the FIFO is empty at the first bit of an unmasked slot, the slot is driven (`sd_oe`=1) with all zeros and nothing is popped.
- R8: When `tx_enable` drops mid-frame, the current frame completes. `active` stays 1 until the last bit has been presented, then reads 0, and `sd_oe` is 0 from that point on.
- R9: `sd_out`, `sd_oe` and `fsync_out` are registered. They change only on the clock edge that samples `bit_en`=1, and they hold otherwise.
- R10: `fsync_oe` equals `master`. In slave mode the block still runs frames but does not drive the sync pin.
- R11: `fifo_pop` pulses for one cycle, together with `bit_en`, at the first bit of every unmasked slot for which `fifo_valid` is 1. The popped `fifo_data` is the word sent in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per serial bit time (driving edge) |
| tx_enable | input | 1 | Transmit enable |
| master | input | 1 | 1 = block drives frame sync |
| sync_pol | input | 1 | 0 = active-high sync, 1 = active-low |
| sync_early | input | 1 | 1 = sync one bit before frame start |
| msb_first | input | 1 | 1 = descending bit index within a slot |
| sync_width | input | 5 | Sync length minus 1, in bits |
| frame_words | input | 5 | Slots per frame minus 1 |
| word0_bits | input | 5 | Slot 0 width minus 1 |
| wordn_bits | input | 5 | Width of slots 1..N minus 1 |
| first_bit | input | 5 | Bit index sent first in each slot |
| slot_mask | input | 32 | Per-slot mask, 1 = pin released, no pop |
| fifo_data | input | 32 | Head word of the source FIFO |
| fifo_valid | input | 1 | FIFO holds at least one word |
| fifo_pop | output | 1 | Consume the head word |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data drive enable |
| fsync_out | output | 1 | Frame sync level |
| fsync_oe | output | 1 | Frame sync drive enable |
| active | output | 1 | Enable readback: 1 while enabled or finishing a frame |

## Verification
Every serial output is due one clock after the edge that sees `bit_en` high. The bench pulses `bit_en` for one cycle on a falling edge, samples on the next falling edge, and then samples twice more before the next pulse to confirm the outputs held. `fifo_pop` is combinational in the `bit_en` cycle, so the bench counts it at the rising edge. The bench compares the total number of pops with the number of unmasked, non-underrun slots once the frames are done. Bit k after enable is predicted from the frame position k-1 (or k-2 with the lead bit of early sync), and `active` is checked both just after the enable falls and after the last frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int MAX_SLOTS = 32;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int SCNT_W    = IDX_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] word;
        logic [IDX_W-1:0]  bitn;
        logic              go;
    } seq_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] wd;
        logic              sd;
        logic              oe;
    } dp_regs_t;

    typedef struct packed {
        logic [SCNT_W-1:0] cnt;
        logic              act;
    } sync_regs_t;
endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic              sync_early,
    input  logic [SLOT_W-1:0] frame_words,
    input  logic [IDX_W-1:0]  word0_bits,
    input  logic [IDX_W-1:0]  wordn_bits,
    output logic              busy,
    output logic              nx_run,
    output logic [SLOT_W-1:0] nx_word,
    output logic [IDX_W-1:0]  nx_bit,
    output logic              nx_wstart,
    output logic              nx_fstart,
    output logic              early_fire
);
    seq_regs_t r_q, r_d;
    logic [IDX_W-1:0] cur_last, nxt_last_idx;
    logic cur_at_last, cont, nx_last;

    always_comb begin
        r_d        = r_q;
        cur_last   = (r_q.word == '0) ? word0_bits : wordn_bits;
        cur_at_last = (r_q.bitn == cur_last);
        cont       = sync_early ? r_q.go : tx_enable;
        if (bit_en) begin
            case (r_q.st)
                ST_IDLE: begin
                    r_d.word = '0;
                    r_d.bitn = '0;
                    if (tx_enable) r_d.st = sync_early ? ST_LEAD : ST_RUN;
                end
                ST_LEAD: begin
                    r_d.st   = ST_RUN;
                    r_d.word = '0;
                    r_d.bitn = '0;
                end
                ST_RUN: begin
                    if (!cur_at_last) begin
                        r_d.bitn = r_q.bitn + 1'b1;
                    end else if (r_q.word != frame_words) begin
                        r_d.word = r_q.word + 1'b1;
                        r_d.bitn = '0;
                    end else begin
                        r_d.word = '0;
                        r_d.bitn = '0;
                        r_d.st   = cont ? ST_RUN : ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
        nxt_last_idx = (r_d.word == '0) ? word0_bits : wordn_bits;
        nx_run    = bit_en && (r_d.st == ST_RUN);
        nx_word   = r_d.word;
        nx_bit    = r_d.bitn;
        nx_wstart = nx_run && (r_d.bitn == '0);
        nx_fstart = nx_wstart && (r_d.word == '0);
        nx_last   = nx_run && (r_d.word == frame_words) && (r_d.bitn == nxt_last_idx);
        if (nx_last) r_d.go = tx_enable;
        early_fire = sync_early && bit_en &&
                     ((r_d.st == ST_LEAD) || (nx_last && tx_enable));
        busy = (r_q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, word: '0, bitn: '0, go: 1'b0};
        else        r_q <= r_d;
    end

    // A slot, once started, is never abandoned before its last bit
    assert_hold_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && r_q.st == ST_RUN && !cur_at_last) |=> (r_q.st == ST_RUN));

    // Enabled, non-early: the last bit of a frame is followed by slot 0 bit 0
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && r_q.st == ST_RUN && cur_at_last && r_q.word == frame_words
         && tx_enable && !sync_early)
        |=> (r_q.st == ST_RUN && r_q.word == '0 && r_q.bitn == '0));
endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
    import tdm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             launch,
    input  logic [IDX_W-1:0] sync_width,
    output logic             fs_act
);
    sync_regs_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (bit_en) begin
            if (launch)            s_d.cnt = SCNT_W'(sync_width) + SCNT_W'(1);
            else if (s_q.cnt != 0) s_d.cnt = s_q.cnt - SCNT_W'(1);
            s_d.act = (s_d.cnt != '0);
        end
        fs_act = s_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_sync_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && launch) |=> fs_act);

    assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(fs_act));
endmodule

// File: rtl/tdm_data_path.sv
module tdm_data_path
    import tdm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 nx_run,
    input  logic [SLOT_W-1:0]    nx_word,
    input  logic [IDX_W-1:0]     nx_bit,
    input  logic                 nx_wstart,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                 msb_first,
    input  logic [IDX_W-1:0]     first_bit,
    input  logic [DATA_W-1:0]    fifo_data,
    input  logic                 fifo_valid,
    output logic                 fifo_pop,
    output logic                 sd,
    output logic                 sd_oe
);
    dp_regs_t d_q, d_d;
    logic [IDX_W-1:0] idx;
    logic masked;

    always_comb begin
        d_d    = d_q;
        fifo_pop = 1'b0;
        masked = slot_mask[nx_word];
        idx    = msb_first ? (first_bit - nx_bit) : (first_bit + nx_bit);
        if (bit_en) begin
            if (nx_wstart && !masked) begin
                fifo_pop = fifo_valid;
                d_d.wd   = fifo_valid ? fifo_data : '0;
            end
            d_d.oe = nx_run && !masked;
            d_d.sd = d_d.oe ? d_d.wd[idx] : 1'b0;
        end
        sd    = d_q.sd;
        sd_oe = d_q.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    // A popped word is always placed on a driven pin on the next bit
    assert_pop_drives_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> sd_oe);

    assert_mask_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!slot_mask[nx_word] && fifo_valid));

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sd) && $stable(sd_oe)));
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 tx_enable,
    input  logic                 master,
    input  logic                 sync_pol,
    input  logic                 sync_early,
    input  logic                 msb_first,
    input  logic [IDX_W-1:0]     sync_width,
    input  logic [SLOT_W-1:0]    frame_words,
    input  logic [IDX_W-1:0]     word0_bits,
    input  logic [IDX_W-1:0]     wordn_bits,
    input  logic [IDX_W-1:0]     first_bit,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic [DATA_W-1:0]    fifo_data,
    input  logic                 fifo_valid,
    output logic                 fifo_pop,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 fsync_out,
    output logic                 fsync_oe,
    output logic                 active
);
    logic              busy, nx_run, nx_wstart, nx_fstart, early_fire, launch, fs_act;
    logic [SLOT_W-1:0] nx_word;
    logic [IDX_W-1:0]  nx_bit;

    tdm_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
        .sync_early(sync_early), .frame_words(frame_words),
        .word0_bits(word0_bits), .wordn_bits(wordn_bits),
        .busy(busy), .nx_run(nx_run), .nx_word(nx_word), .nx_bit(nx_bit),
        .nx_wstart(nx_wstart), .nx_fstart(nx_fstart), .early_fire(early_fire)
    );

    always_comb launch = sync_early ? early_fire : nx_fstart;

    tdm_sync_gen u_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .launch(launch),
        .sync_width(sync_width), .fs_act(fs_act)
    );

    tdm_data_path u_dp (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nx_run(nx_run),
        .nx_word(nx_word), .nx_bit(nx_bit), .nx_wstart(nx_wstart),
        .slot_mask(slot_mask), .msb_first(msb_first), .first_bit(first_bit),
        .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_pop(fifo_pop),
        .sd(sd_out), .sd_oe(sd_oe)
    );

    always_comb begin
        fsync_out = fs_act ^ sync_pol;
        fsync_oe  = master;
        active    = tx_enable | busy;
    end

    assert_drive_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> active);
endmodule

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, tx_enable = 1'b0, master = 1'b1, sync_pol = 1'b0;
    logic sync_early = 1'b0, msb_first = 1'b1;
    logic [4:0] sync_width = '0, frame_words = '0, word0_bits = '0, wordn_bits = '0, first_bit = '0;
    logic [31:0] slot_mask = '0;
    logic [31:0] fifo_data;
    logic fifo_valid, fifo_pop, sd_out, sd_oe, fsync_out, fsync_oe, active;

    int n_checks = 0, n_fail = 0;
    logic [31:0] mem [0:63];
    int fill = 0;
    int rd_idx;

    always #2 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rd_idx <= 0;
        else if (fifo_pop) rd_idx <= rd_idx + 1;

    assign fifo_valid = (rd_idx < fill);
    assign fifo_data  = mem[rd_idx % 64];

    tdm_tx_serializer u_tdm_tx_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
        .master(master), .sync_pol(sync_pol), .sync_early(sync_early),
        .msb_first(msb_first), .sync_width(sync_width), .frame_words(frame_words),
        .word0_bits(word0_bits), .wordn_bits(wordn_bits), .first_bit(first_bit),
        .slot_mask(slot_mask), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
        .fifo_pop(fifo_pop), .sd_out(sd_out), .sd_oe(sd_oe), .fsync_out(fsync_out),
        .fsync_oe(fsync_oe), .active(active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int nfill);
        tx_enable = 1'b0;
        bit_en = 1'b0;
        fill = nfill;
        for (int i = 0; i < 64; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ 32'h5A5A0F0F;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One bit time: pulse, sample after the edge, confirm hold (R9)
    logic [2:0] smp;
    task automatic step();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        smp = {fsync_out, sd_oe, sd_out};
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check({fsync_out, sd_oe, sd_out} == smp, "R9 hold", {fsync_out, sd_oe, sd_out}, smp);
        end
    endtask

    function automatic int unmasked_before(input int w);
        int c = 0;
        for (int i = 0; i < w; i++) if (!slot_mask[i]) c++;
        return c;
    endfunction

    // Expected {fs_active, oe, sd} for bit time t (1-based) of an nfr-frame run
    function automatic logic [2:0] expect_at(input int t, input int nfr);
        int e, w0, wn, nw, len, u, rel, f, p, w, b, idx, k;
        logic fs, oe, sd;
        e = sync_early; w0 = word0_bits + 1; wn = wordn_bits + 1; nw = frame_words + 1;
        len = w0 + (nw - 1) * wn;
        u = unmasked_before(nw);
        fs = 1'b0; oe = 1'b0; sd = 1'b0;
        for (int fr = 0; fr < nfr; fr++) begin
            int s = 1 + e + fr * len;
            if (t >= s - e && t <= s - e + sync_width) fs = 1'b1;
        end
        rel = t - 1 - e;
        if (rel >= 0 && rel < nfr * len) begin
            f = rel / len; p = rel % len;
            if (p < w0) begin w = 0; b = p; end
            else begin w = 1 + (p - w0) / wn; b = (p - w0) % wn; end
            if (!slot_mask[w]) begin
                oe = 1'b1;
                idx = msb_first ? ((first_bit - b) & 31) : ((first_bit + b) & 31);
                k = f * u + unmasked_before(w);
                sd = (k < fill) ? mem[k][idx] : 1'b0;
            end
        end
        return {fs, oe, sd};
    endfunction

    task automatic run_frames(input string tag, input int nfr);
        int len, total, drop_t, u, exp_pops;
        logic [2:0] ex;
        len = (word0_bits + 1) + frame_words * (wordn_bits + 1);
        total = sync_early + nfr * len + 3;
        drop_t = sync_early + (nfr - 1) * len + 1;
        u = unmasked_before(frame_words + 1);
        exp_pops = (nfr * u < fill) ? nfr * u : fill;
        @(negedge clk) tx_enable = 1'b1;
        for (int t = 1; t <= total; t++) begin
            step();
            ex = expect_at(t, nfr);
            ex[2] = ex[2] ^ sync_pol;
            check(smp == ex, tag, smp, ex);
            if (t == drop_t) begin
                tx_enable = 1'b0;
                @(negedge clk);
                check(active == 1'b1, "R8 active after mid-frame disable", active, 1);
            end
        end
        check(active == 1'b0 && sd_oe == 1'b0, "R8 idle after last frame", {active, sd_oe}, 0);
        check(rd_idx == exp_pops, {tag, " R11 pop count"}, rd_idx, exp_pops);
    endtask

    task automatic t_reset();
        sync_pol = 1'b1; master = 1'b1;
        do_reset(8);
        check(sd_oe == 0 && sd_out == 0, "R1 data pin idle", {sd_oe, sd_out}, 0);
        check(fsync_out == 1'b1, "R1 sync inactive (active-low)", fsync_out, 1);
        check(active == 0 && fifo_pop == 0, "R1 active/pop", {active, fifo_pop}, 0);
        check(fsync_oe == 1'b1, "R10 master drives sync", fsync_oe, 1);
        master = 1'b0; #1;
        check(fsync_oe == 1'b0, "R10 slave releases sync", fsync_oe, 0);
        master = 1'b1; sync_pol = 1'b0;
    endtask

    task automatic t_basic();
        sync_early = 0; msb_first = 1; sync_width = 0; frame_words = 3;
        word0_bits = 7; wordn_bits = 7; first_bit = 7; slot_mask = '0;
        do_reset(32);
        run_frames("R2 R3 msb basic", 2);
    endtask

    task automatic t_lsb_mixed();
        sync_early = 0; msb_first = 0; sync_width = 3; sync_pol = 1; frame_words = 2;
        word0_bits = 15; wordn_bits = 7; first_bit = 0; slot_mask = '0;
        do_reset(32);
        run_frames("R3 lsb R2 word0 width R4 sync", 2);
        sync_pol = 0;
    endtask

    task automatic t_early();
        sync_early = 1; msb_first = 1; sync_width = 1; frame_words = 1;
        word0_bits = 5; wordn_bits = 5; first_bit = 5; slot_mask = '0;
        do_reset(32);
        run_frames("R5 early sync", 3);
        sync_early = 0;
    endtask

    task automatic t_mask();
        sync_early = 0; msb_first = 1; sync_width = 0; frame_words = 3;
        word0_bits = 3; wordn_bits = 3; first_bit = 3; slot_mask = 32'h0000_000A;
        do_reset(32);
        run_frames("R6 masked slots", 2);
        slot_mask = '0;
    endtask

    task automatic t_underrun();
        sync_early = 0; msb_first = 1; sync_width = 0; frame_words = 3;
        word0_bits = 3; wordn_bits = 3; first_bit = 3; slot_mask = '0;
        do_reset(3);
        run_frames("R7 underrun zeros", 2);
    endtask

    task automatic t_wrap();
        sync_early = 0; msb_first = 1; sync_width = 2; frame_words = 1;
        word0_bits = 7; wordn_bits = 7; first_bit = 3; slot_mask = '0;
        do_reset(32);
        run_frames("R3 index wrap", 2);
    endtask

    task automatic t_slave();
        master = 0; sync_early = 0; msb_first = 0; frame_words = 0;
        word0_bits = 4; wordn_bits = 4; first_bit = 2; sync_width = 0;
        do_reset(32);
        check(fsync_oe == 1'b0, "R10 slave no sync drive", fsync_oe, 0);
        run_frames("R10 slave frames", 2);
        master = 1;
    endtask

    bit done = 0;
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_lsb_mixed();
        t_early();
        t_mask();
        t_underrun();
        t_wrap();
        t_slave();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule